// File: doc/BRIEF.md
# Video Controller Bus Port Decoder

This block sits between the host processor bus and the internals of a tile-based video display controller. It decodes a 32-byte I/O window into four ports, each reachable at several mirrored offsets: a pixel-data port, a control port, a read-only beam-position port and a byte-wide port for the integrated sound generator. Traffic to the data port and the sound generator is forwarded as single-cycle strobes. Reads of the data and control ports return a word supplied from outside the block.

Words written to the control port are sorted into two kinds. A word with its top bit set is a register write. It loads its low byte into one of 24 configuration registers. Any other word leaves the block as a command strobe for the access engine. The configuration registers drive a set of decoded outputs: display enable, DMA enable, the two interrupt enables, the vertical cell mode, a request to freeze the beam counter, and three name-table base addresses that are aligned per plane.

Top module: `vid_bus_port`

## Requirements
- R1: Byte offsets whose bits [4:2] are 000 (0x0, 0x2) select the data port. A write there pulses `data_wr` with `fwd_word` equal to the bus word. A read there pulses `data_rd` and returns `ext_rdata` on `bus_rdata`.
- R2: Byte offsets whose bits [4:2] are 001 (0x4, 0x6) select the control port. A read there pulses `ctrl_rd` and returns `ext_rdata`.
- R3: Byte offsets whose bits [4:3] are 01 (0x8 to 0xE) select the beam-position port. A read there returns `beam_count`. A write there produces no strobe and changes no configuration output.
- R4: Odd byte offsets 0x11, 0x13, 0x15 and 0x17 select the sound port. A write there pulses `snd_wr`, and `snd_byte` equals bus bits [7:0]. A read there returns zero.
- R5: Every other offset, including even offsets 0x10 to 0x16 and all offsets from 0x18 up, is unmapped. It produces no strobe and reads as zero. Writes never drive `bus_rdata`, so it reads zero during any write.
- R6: A control-port write with bit 15 set and index bits [14:8] below 24 loads bits [7:0] into the register with that index, visible after the next clock edge. A control-port write with bit 15 clear pulses `cmd_wr`, carries the word on `fwd_word`, and changes no register.
- R7: A control-port write with bit 15 set and an index of 24 or more changes no configuration output and raises no `cmd_wr`.
- R8: Register 0 bit 4 drives `hint_en` and bit 1 drives `beam_freeze`.
- R9: Register 1 drives four outputs: bit 6 drives `disp_en`, bit 5 drives `vint_en`, bit 4 drives `dma_en`, and bit 3 drives `cell30` (1 selects 30-cell height).
- R10: `plane_a_base` equals register 2 bits [5:3] times 0x400. `window_base` equals register 3 bits [5:3] times 0x400.
- R11: `plane_b_base` equals register 4 bits [2:0] times 0x2000.
- R12: After reset all configuration outputs and all three bases are zero.
- R13: Control-port writes in consecutive cycles, for example at 0x4 and then 0x6, both take effect in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte offset inside the window |
| bus_wdata | input | 16 | Write word |
| bus_rdata | output | 16 | Read word |
| ext_rdata | input | 16 | Word returned for data and control port reads |
| beam_count | input | 16 | Current beam position |
| data_wr | output | 1 | Data port write strobe |
| data_rd | output | 1 | Data port read strobe |
| ctrl_rd | output | 1 | Control port read strobe |
| cmd_wr | output | 1 | Non-register control word strobe |
| fwd_word | output | 16 | Word forwarded with `data_wr` or `cmd_wr` |
| snd_wr | output | 1 | Sound port write strobe |
| snd_byte | output | 8 | Byte forwarded with `snd_wr` |
| hint_en | output | 1 | Line interrupt enable |
| beam_freeze | output | 1 | Beam counter freeze request |
| disp_en | output | 1 | Display enable |
| vint_en | output | 1 | Vertical-blank interrupt enable |
| dma_en | output | 1 | DMA enable |
| cell30 | output | 1 | 30-cell vertical mode |
| plane_a_base | output | 16 | Plane A name-table base |
| window_base | output | 16 | Window name-table base |
| plane_b_base | output | 16 | Plane B name-table base |

## Verification
The assertions take two things for granted about the inputs. First, `bus_we` and `bus_wdata` are meaningful only while `bus_sel` is high. Second, each bus access lasts exactly one cycle, so a single strobe maps to a single register update. The bench keeps to these assumptions in two ways. It changes the bus inputs only on the falling edge, and it holds every access for exactly one cycle, with a random idle gap or none. It biases the random words toward register-write headers, covering indices around the 24 boundary, plus plain command words. This keeps the configuration outputs busy while the offsets sweep all 32 values.

// File: rtl/vbp_pkg.sv
package vbp_pkg;

    localparam int NUM_REGS = 24;
    localparam int REG_W    = 8;
    localparam int WORD_W   = 16;
    localparam int ADDR_W   = 5;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int HDR_W    = 7;

    typedef enum logic [2:0] {
        PORT_NONE,
        PORT_DATA,
        PORT_CTRL,
        PORT_BEAM,
        PORT_SND
    } port_e;

    typedef logic [NUM_REGS-1:0][REG_W-1:0] reg_file_t;

    // bits a register write may change
    function automatic logic [REG_W-1:0] wr_mask(input int idx);
        case (idx)
            0:       return 8'h12;
            1:       return 8'h78;
            2, 3:    return 8'h38;
            4:       return 8'h07;
            default: return 8'hFF;
        endcase
    endfunction

    // bits tied high regardless of writes
    function automatic logic [REG_W-1:0] fix_mask(input int idx);
        case (idx)
            0, 1:    return 8'h04;
            default: return 8'h00;
        endcase
    endfunction

    function automatic reg_file_t reset_file();
        reg_file_t f;
        for (int i = 0; i < NUM_REGS; i++) begin
            f[i] = fix_mask(i);
        end
        return f;
    endfunction

endpackage

// File: rtl/vbp_addr_dec.sv
module vbp_addr_dec
    import vbp_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    output port_e         port
);

    always_comb begin
        port = PORT_NONE;
        case (addr[AW-1:2])
            3'b000:       port = PORT_DATA;
            3'b001:       port = PORT_CTRL;
            3'b010,
            3'b011:       port = PORT_BEAM;
            3'b100,
            3'b101:       port = addr[0] ? PORT_SND : PORT_NONE;
            default:      port = PORT_NONE;
        endcase
    end

endmodule

// File: rtl/vbp_ctrl_split.sv
module vbp_ctrl_split
    import vbp_pkg::*;
#(
    parameter int NREG = NUM_REGS,
    parameter int WW   = WORD_W
) (
    input  logic             ctrl_wr,
    input  logic [WW-1:0]    word,
    output logic             reg_wr_en,
    output logic [IDX_W-1:0] reg_idx,
    output logic [REG_W-1:0] reg_data,
    output logic             cmd_wr
);

    localparam int MARK_BIT = WW - 1;

    logic             marked;
    logic [HDR_W-1:0] hdr_idx;
    logic             in_range;

    always_comb begin
        marked    = word[MARK_BIT];
        hdr_idx   = word[MARK_BIT-1 -: HDR_W];
        in_range  = (hdr_idx < HDR_W'(NREG));
        reg_wr_en = ctrl_wr && marked && in_range;
        reg_idx   = hdr_idx[IDX_W-1:0];
        reg_data  = word[REG_W-1:0];
        cmd_wr    = ctrl_wr && !marked;
    end

    always_comb begin
        a_excl_r6: assert (!(reg_wr_en && cmd_wr));
    end

endmodule

// File: rtl/vbp_reg_bank.sv
module vbp_reg_bank
    import vbp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [REG_W-1:0] wr_data,
    output reg_file_t        regs
);

    typedef struct packed {
        reg_file_t file;
    } state_t;

    state_t    state_d;
    state_t    state_q;
    reg_file_t wmask;
    reg_file_t fmask;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_mask
        assign wmask[g] = wr_mask(g);
        assign fmask[g] = fix_mask(g);
    end

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                state_d.file[i] = (wr_data & wmask[i]) | fmask[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.file <= reset_file();
        end else begin
            state_q <= state_d;
        end
    end

    assign regs = state_q.file;

    // R7: without an accepted write the bank holds its contents
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(state_q));

endmodule

// File: rtl/vid_bus_port.sv
module vid_bus_port
    import vbp_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int WW = WORD_W,
    parameter int BW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [WW-1:0] bus_wdata,
    output logic [WW-1:0] bus_rdata,
    input  logic [WW-1:0] ext_rdata,
    input  logic [WW-1:0] beam_count,
    output logic          data_wr,
    output logic          data_rd,
    output logic          ctrl_rd,
    output logic          cmd_wr,
    output logic [WW-1:0] fwd_word,
    output logic          snd_wr,
    output logic [7:0]    snd_byte,
    output logic          hint_en,
    output logic          beam_freeze,
    output logic          disp_en,
    output logic          vint_en,
    output logic          dma_en,
    output logic          cell30,
    output logic [BW-1:0] plane_a_base,
    output logic [BW-1:0] window_base,
    output logic [BW-1:0] plane_b_base
);

    localparam int SHIFT_FINE   = 10;
    localparam int SHIFT_COARSE = 13;

    port_e            port;
    logic             rd_cyc;
    logic             wr_cyc;
    logic             ctrl_wr;
    logic             reg_wr_en;
    logic [IDX_W-1:0] reg_idx;
    logic [REG_W-1:0] reg_data;
    reg_file_t        regs;

    vbp_addr_dec #(.AW(AW)) u_dec (
        .addr (bus_addr),
        .port (port)
    );

    assign rd_cyc  = bus_sel && !bus_we;
    assign wr_cyc  = bus_sel && bus_we;
    assign ctrl_wr = wr_cyc && (port == PORT_CTRL);

    vbp_ctrl_split #(.NREG(NUM_REGS), .WW(WW)) u_split (
        .ctrl_wr   (ctrl_wr),
        .word      (bus_wdata),
        .reg_wr_en (reg_wr_en),
        .reg_idx   (reg_idx),
        .reg_data  (reg_data),
        .cmd_wr    (cmd_wr)
    );

    vbp_reg_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_idx  (reg_idx),
        .wr_data (reg_data),
        .regs    (regs)
    );

    always_comb begin
        data_wr  = wr_cyc && (port == PORT_DATA);
        data_rd  = rd_cyc && (port == PORT_DATA);
        ctrl_rd  = rd_cyc && (port == PORT_CTRL);
        snd_wr   = wr_cyc && (port == PORT_SND);
        fwd_word = bus_wdata;
        snd_byte = bus_wdata[7:0];
        bus_rdata = '0;
        if (rd_cyc) begin
            case (port)
                PORT_DATA, PORT_CTRL: bus_rdata = ext_rdata;
                PORT_BEAM:            bus_rdata = beam_count;
                default:              bus_rdata = '0;
            endcase
        end
    end

    always_comb begin
        hint_en      = regs[0][4];
        beam_freeze  = regs[0][1];
        disp_en      = regs[1][6];
        vint_en      = regs[1][5];
        dma_en       = regs[1][4];
        cell30       = regs[1][3];
        plane_a_base = BW'({regs[2][5:3], SHIFT_FINE'(0)});
        window_base  = BW'({regs[3][5:3], SHIFT_FINE'(0)});
        plane_b_base = BW'({regs[4][2:0], SHIFT_COARSE'(0)});
    end

    // R1: at most one port strobe per cycle
    p_strobe_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_wr, data_rd, ctrl_rd, cmd_wr, snd_wr}));

    // R5: a read never raises a write strobe
    p_rd_no_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |-> !(data_wr || cmd_wr || snd_wr));

    // R3: writes to the beam port leave configuration untouched
    p_beam_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr[AW-1:3] == 2'b01)
        |=> $stable({disp_en, dma_en, hint_en, vint_en, cell30, beam_freeze,
                     plane_a_base, window_base, plane_b_base}));

    // R10: a register 2 write lands in the plane A base on the next edge
    p_plane_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[WW-1:8] == 8'h82)
        |=> plane_a_base[12:10] == $past(bus_wdata[5:3]));

    // R11: a register 4 write lands in the plane B base on the next edge
    p_plane_b_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[WW-1:8] == 8'h84)
        |=> plane_b_base[15:13] == $past(bus_wdata[2:0]));

    // R7: an out-of-range register header leaves every output as it was
    p_oor_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[WW-1] && bus_wdata[WW-2:8] >= 7'd24)
        |=> $stable({disp_en, dma_en, hint_en, vint_en, cell30, beam_freeze,
                     plane_a_base, window_base, plane_b_base}));

endmodule

// File: tb/tb_vid_bus_port.sv
module tb_vid_bus_port;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_we;
    logic [4:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata, ext_rdata, beam_count;
    logic        data_wr, data_rd, ctrl_rd, cmd_wr, snd_wr;
    logic [15:0] fwd_word;
    logic [7:0]  snd_byte;
    logic        hint_en, beam_freeze, disp_en, vint_en, dma_en, cell30;
    logic [15:0] plane_a_base, window_base, plane_b_base;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [7:0] shadow [0:4];

    always #4 clk = ~clk;

    vid_bus_port dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_rdata(ext_rdata), .beam_count(beam_count),
        .data_wr(data_wr), .data_rd(data_rd), .ctrl_rd(ctrl_rd),
        .cmd_wr(cmd_wr), .fwd_word(fwd_word), .snd_wr(snd_wr),
        .snd_byte(snd_byte), .hint_en(hint_en), .beam_freeze(beam_freeze),
        .disp_en(disp_en), .vint_en(vint_en), .dma_en(dma_en),
        .cell30(cell30), .plane_a_base(plane_a_base),
        .window_base(window_base), .plane_b_base(plane_b_base)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // 0 none, 1 data, 2 ctrl, 3 beam, 4 sound
    function automatic int port_of(input logic [4:0] a);
        if (a[4:2] == 3'b000) return 1;
        if (a[4:2] == 3'b001) return 2;
        if (a[4:3] == 2'b01)  return 3;
        if (a[4:3] == 2'b10 && a[0]) return 4;
        return 0;
    endfunction

    function automatic logic [63:0] cfg_exp();
        return {10'd0, shadow[0][4], shadow[0][1], shadow[1][6], shadow[1][5],
                shadow[1][4], shadow[1][3],
                3'b000, shadow[2][5:3], 10'd0,
                3'b000, shadow[3][5:3], 10'd0,
                shadow[4][2:0], 13'd0};
    endfunction

    function automatic logic [63:0] cfg_act();
        return {10'd0, hint_en, beam_freeze, disp_en, vint_en, dma_en, cell30,
                plane_a_base, window_base, plane_b_base};
    endfunction

    function automatic string tag_of(input int p, input bit w, input logic [15:0] d);
        if (p == 1) return "R1";
        if (p == 2) return (w && !d[15]) ? "R6" : "R2";
        if (p == 3) return "R3";
        if (p == 4) return "R4";
        return "R5";
    endfunction

    // call at a falling edge; holds the access for exactly one cycle
    task automatic op(input logic [4:0] a, input bit w, input logic [15:0] d);
        int p;
        logic [4:0] es;
        logic [15:0] er;
        string t;
        p = port_of(a);
        bus_sel = 1'b1; bus_we = w; bus_addr = a; bus_wdata = d;
        ext_rdata = 16'($urandom); beam_count = 16'($urandom);
        #1;
        t = tag_of(p, w, d);
        es = {w && p == 1, !w && p == 1, !w && p == 2,
              w && p == 2 && !d[15], w && p == 4};
        chk({data_wr, data_rd, ctrl_rd, cmd_wr, snd_wr} == es, t,
            64'({data_wr, data_rd, ctrl_rd, cmd_wr, snd_wr}), 64'(es));
        er = 16'h0;
        if (!w && (p == 1 || p == 2)) er = ext_rdata;
        if (!w && p == 3) er = beam_count;
        chk(bus_rdata == er, t, 64'(bus_rdata), 64'(er));
        if (es[4] || es[1]) chk(fwd_word == d, t, 64'(fwd_word), 64'(d));
        if (es[0]) chk(snd_byte == d[7:0], "R4", 64'(snd_byte), 64'(d[7:0]));
        @(posedge clk);
        if (w && p == 2 && d[15] && d[14:8] < 7'd24 && d[14:8] <= 7'd4)
            shadow[d[10:8]] = d[7:0];
        @(negedge clk);
        if (w && p == 2 && d[15] && d[14:8] >= 7'd24)
            chk(cfg_act() == cfg_exp(), "R7", cfg_act(), cfg_exp());
        else
            chk(cfg_act() == cfg_exp(), "R6 R8 R9 R10 R11",
                cfg_act(), cfg_exp());
    endtask

    task automatic idle();
        bus_sel = 1'b0; bus_we = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5eed1234));
        for (int i = 0; i < 5; i++) shadow[i] = 8'h00;
        rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0;
        bus_wdata = '0; ext_rdata = '0; beam_count = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(cfg_act() == 64'd0, "R12", cfg_act(), 64'd0);

        // R8, R9, R10, R11 directed field writes
        op(5'h04, 1, 16'h80FF);
        op(5'h04, 1, 16'h81FF);
        op(5'h06, 1, 16'h8228);
        op(5'h04, 1, 16'h8310);
        op(5'h06, 1, 16'h8405);
        op(5'h04, 1, 16'h8102);
        // R7: out-of-range indices
        op(5'h04, 1, 16'h9800);
        op(5'h06, 1, 16'hFFFF);
        op(5'h04, 1, 16'hA012);
        // R6: command word
        op(5'h06, 1, 16'h4321);
        // R13: back-to-back pair at 0x4 then 0x6 touching the same register
        op(5'h04, 1, 16'h8138);
        op(5'h06, 1, 16'h8148);
        idle();
        // R1 to R5 reads and writes on every offset
        for (int a = 0; a < 32; a++) begin
            op(5'(a), 0, 16'($urandom));
            op(5'(a), 1, 16'($urandom) & 16'h7FFF);
        end
        // R3 beam port write with a register header must not load it
        op(5'h0A, 1, 16'h81FF);

        for (int i = 0; i < 600; i++) begin
            logic [4:0] a;
            bit w;
            logic [15:0] d;
            case ($urandom % 4)
                0: d = {1'b1, 7'($urandom % 28), 8'($urandom)};
                1: d = {5'b10000, 3'($urandom % 5), 8'($urandom)};
                2: d = 16'($urandom);
                default: d = {1'b0, 15'($urandom)};
            endcase
            if ($urandom % 2) begin
                a = 5'($urandom % 2 ? 6 : 4);
                w = 1'b1;
            end else begin
                a = 5'($urandom);
                w = 1'($urandom);
            end
            op(a, w, d);
            if ($urandom % 3 == 0) idle();
        end

        idle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule